// File: doc/BRIEF.md
# Peripheral Chip-Select Decoder

This block turns the latched address of a bus cycle into one of four active-low peripheral chip selects. The peripheral block is placed at a programmable base. Bits above the block size must equal that base, and the access must target the space chosen for the block (memory or I/O). The block is made of four 256-byte windows that follow one another upward from the base, so address bits 9:8 pick the window. The select is registered. It appears in the cycle right after the clock edge that samples the address-valid strobe, which is the same bus phase in which the multiplexed address is on the bus. It stays low until the bus cycle ends.

A granted bus hold and reset both force every select high. When hardware flow control for serial port 1 is enabled, select 2 loses its pin and is kept high. The other three selects work as before. The base and space settings come from outside the block and are assumed to be stable during a bus cycle. The reset input is assumed to be deasserted synchronously to the clock.

Top module: `pcs_decoder`

## Requirements
- R1: While `rst_n` is low, `pcs_n` is 4'b1111. Reset takes effect without waiting for a clock edge.
- R2: A clock edge with `addr_valid`=1 that samples an address with addr[19:10] equal to `cfg_base` and `io_space` equal to `cfg_in_io` drives `pcs_n[k]` low in the next cycle, where k = addr[9:8]. All other selects are high (bit k of `pcs_n` belongs to select k).
- R3: An access whose space bit (1 = I/O, 0 = memory) differs from `cfg_in_io` asserts no select, even when the address matches.
- R4: An access whose addr[19:10] differs from `cfg_base` in any bit asserts no select.
- R5: An asserted select stays low through the following cycles until a clock edge samples `cycle_end`=1 with no new `addr_valid`. From the next cycle on, all selects are high.
- R6: After any clock edge that samples `bus_hold`=1, every select is high. Strobes sampled during the hold are ignored, and no select is active after the hold is released until a new strobe arrives.
- R7: After any clock edge that samples `flow_ctl_en`=1, `pcs_n[2]` is high. An access to window 2 then asserts nothing, and the other windows are unaffected.
- R8: At most one bit of `pcs_n` is low in any cycle.
- R9: A new strobe sampled while a select is active replaces it with the decode of the new address. This also holds when `cycle_end` is sampled at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| addr | input | 20 | Latched bus address |
| addr_valid | input | 1 | Address strobe, one cycle at the start of a bus cycle |
| cycle_end | input | 1 | Bus cycle end, one cycle |
| io_space | input | 1 | Access space, 1 = I/O, 0 = memory |
| cfg_base | input | 10 | Peripheral block base, address bits 19:10 |
| cfg_in_io | input | 1 | Peripheral block space, 1 = I/O, 0 = memory |
| bus_hold | input | 1 | Bus hold granted |
| flow_ctl_en | input | 1 | Serial port 1 hardware flow control enabled |
| pcs_n | output | 4 | Active-low peripheral selects, bit k = select k |

## Verification
Some rules are checked by assertions on every cycle. These are that at most one select is low, that every select is high after a sampled hold, that select 2 is high after flow control was seen, and that no select follows a space mismatch or a cycle end. Other behaviour can only be shown by the bench's scenarios against its reference model. That covers the window a given address picks, whether a base mismatch in a single bit suppresses the select, how long a select lasts, back-to-back replacement, strobes ignored during a hold, and a reset applied in the middle of a cycle.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int unsigned PCS_ADDR_W   = 20;
  localparam int unsigned PCS_NUM_SEL  = 4;
  localparam int unsigned PCS_WIN_BITS = 8;
  localparam int unsigned PCS_FC_SEL   = 2;

  typedef enum logic {
    SPACE_MEM = 1'b0,
    SPACE_IO  = 1'b1
  } pcs_space_e;
endpackage

// File: rtl/pcs_window_match.sv
module pcs_window_match #(
  parameter int unsigned BASE_W = 10
) (
  input  logic [BASE_W-1:0] addr_hi,
  input  logic              io_space,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic              cfg_in_io,
  output logic              hit
);
  import pcs_pkg::*;

  pcs_space_e acc_space;
  pcs_space_e blk_space;
  logic       base_eq;

  always_comb begin
    acc_space = pcs_space_e'(io_space);
    blk_space = pcs_space_e'(cfg_in_io);
    base_eq   = (addr_hi == cfg_base);
    hit       = base_eq && (acc_space == blk_space);
  end
endmodule

// File: rtl/pcs_index_decode.sv
module pcs_index_decode #(
  parameter int unsigned NUM_SEL = 4,
  parameter int unsigned FC_SEL  = 2,
  localparam int unsigned IDX_W  = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1
) (
  input  logic [IDX_W-1:0]   idx,
  input  logic               hit,
  input  logic               flow_ctl_en,
  output logic [NUM_SEL-1:0] req,
  output logic [NUM_SEL-1:0] fc_mask
);
  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
    if (i == FC_SEL) begin : g_shared
      assign fc_mask[i] = flow_ctl_en;
    end else begin : g_plain
      assign fc_mask[i] = 1'b0;
    end
    assign req[i] = hit && (idx == IDX_W'(i)) && !fc_mask[i];
  end
endmodule

// File: rtl/pcs_out_reg.sv
module pcs_out_reg #(
  parameter int unsigned NUM_SEL = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strobe,
  input  logic               cycle_end,
  input  logic               bus_hold,
  input  logic [NUM_SEL-1:0] req,
  input  logic [NUM_SEL-1:0] fc_mask,
  output logic [NUM_SEL-1:0] pcs_n
);
  logic [NUM_SEL-1:0] active_q;
  logic [NUM_SEL-1:0] active_d;
  logic               load_en;

  always_comb begin
    active_d = active_q;
    if (bus_hold) begin
      active_d = '0;
    end else if (strobe) begin
      active_d = req;
    end else if (cycle_end) begin
      active_d = '0;
    end
    active_d = active_d & ~fc_mask;
    load_en  = bus_hold || strobe || cycle_end || (|(active_q & fc_mask));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
    end else if (load_en) begin
      active_q <= active_d;
    end
  end

  assign pcs_n = ~active_q;

  // R6
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_hold) |-> (&pcs_n));

  // R5
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cycle_end && !strobe) |-> (&pcs_n));

  // R7
  flow_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(|fc_mask) |-> (&(pcs_n | ~$past(fc_mask))));
endmodule

// File: rtl/pcs_decoder.sv
module pcs_decoder
  import pcs_pkg::*;
#(
  parameter int unsigned ADDR_W   = PCS_ADDR_W,
  parameter int unsigned NUM_SEL  = PCS_NUM_SEL,
  parameter int unsigned WIN_BITS = PCS_WIN_BITS,
  parameter int unsigned FC_SEL   = PCS_FC_SEL,
  localparam int unsigned IDX_W    = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1,
  localparam int unsigned BASE_LSB = WIN_BITS + IDX_W,
  localparam int unsigned BASE_W   = ADDR_W - BASE_LSB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               addr_valid,
  input  logic               cycle_end,
  input  logic               io_space,
  input  logic [BASE_W-1:0]  cfg_base,
  input  logic               cfg_in_io,
  input  logic               bus_hold,
  input  logic               flow_ctl_en,
  output logic [NUM_SEL-1:0] pcs_n
);
  logic               hit;
  logic [NUM_SEL-1:0] req;
  logic [NUM_SEL-1:0] fc_mask;
  logic               unused_low;

  assign unused_low = ^addr[WIN_BITS-1:0];

  pcs_window_match #(
    .BASE_W   (BASE_W)
  ) u_match (
    .addr_hi  (addr[ADDR_W-1:BASE_LSB]),
    .io_space (io_space),
    .cfg_base (cfg_base),
    .cfg_in_io(cfg_in_io),
    .hit      (hit)
  );

  pcs_index_decode #(
    .NUM_SEL    (NUM_SEL),
    .FC_SEL     (FC_SEL)
  ) u_decode (
    .idx        (addr[BASE_LSB-1:WIN_BITS]),
    .hit        (hit),
    .flow_ctl_en(flow_ctl_en),
    .req        (req),
    .fc_mask    (fc_mask)
  );

  pcs_out_reg #(
    .NUM_SEL  (NUM_SEL)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (addr_valid),
    .cycle_end(cycle_end),
    .bus_hold (bus_hold),
    .req      (req),
    .fc_mask  (fc_mask),
    .pcs_n    (pcs_n)
  );

  // R8
  at_most_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~pcs_n) <= 1);

  // R3
  space_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(addr_valid && !bus_hold && (io_space != cfg_in_io)) |-> (&pcs_n));
endmodule

// File: tb/pcs_decoder_tb.sv
module pcs_decoder_tb;
  logic        clk;
  logic        rst_n;
  logic [19:0] addr;
  logic        addr_valid;
  logic        cycle_end;
  logic        io_space;
  logic [9:0]  cfg_base;
  logic        cfg_in_io;
  logic        bus_hold;
  logic        flow_ctl_en;
  logic [3:0]  pcs_n;

  int tests;
  int fails;
  int exp_sel;

  pcs_decoder u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .addr_valid (addr_valid),
    .cycle_end  (cycle_end),
    .io_space   (io_space),
    .cfg_base   (cfg_base),
    .cfg_in_io  (cfg_in_io),
    .bus_hold   (bus_hold),
    .flow_ctl_en(flow_ctl_en),
    .pcs_n      (pcs_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [3:0] expect_n(input int s);
    logic [3:0] v;
    v = 4'hF;
    if (s >= 0) v[s] = 1'b0;
    return v;
  endfunction

  task automatic model_step();
    int nxt;
    int win;
    nxt = exp_sel;
    if (!rst_n) nxt = -1;
    else if (bus_hold) nxt = -1;
    else if (addr_valid) begin
      win = int'(addr[9:8]);
      if (addr[19:10] == cfg_base && io_space == cfg_in_io) nxt = win;
      else nxt = -1;
    end else if (cycle_end) nxt = -1;
    if (flow_ctl_en && nxt == 2) nxt = -1;
    exp_sel = nxt;
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    tests++;
    if (pcs_n !== expect_n(exp_sel)) begin
      fails++;
      $display("FAIL %s: pcs_n=%b expected %b", tag, pcs_n, expect_n(exp_sel));
    end
  endtask

  task automatic access(input logic [19:0] a, input logic sp, input string tag);
    addr       = a;
    io_space   = sp;
    addr_valid = 1'b1;
    tick(tag);
    addr_valid = 1'b0;
  endtask

  task automatic finish_cycle(input string tag);
    cycle_end = 1'b1;
    tick(tag);
    cycle_end = 1'b0;
    tick(tag);
  endtask

  function automatic logic [19:0] win_addr(input int w, input logic [7:0] lo);
    return {cfg_base, w[1:0], lo};
  endfunction

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0; fails = 0; exp_sel = -1;
    rst_n = 1'b0; addr = '0; addr_valid = 1'b0; cycle_end = 1'b0;
    io_space = 1'b0; cfg_base = 10'h2A3; cfg_in_io = 1'b0;
    bus_hold = 1'b0; flow_ctl_en = 1'b0;

    // R1: selects idle during reset, even with a matching strobe
    tick("R1");
    access(win_addr(1, 8'h10), 1'b0, "R1");
    tick("R1");
    rst_n = 1'b1;
    tick("R1");

    // R2: every window in memory space, held over several cycles (R5)
    for (int w = 0; w < 4; w++) begin
      access(win_addr(w, 8'(w * 37)), 1'b0, "R2");
      tick("R5"); tick("R5");
      finish_cycle("R5");
    end

    // R2: I/O placement
    cfg_in_io = 1'b1;
    access(win_addr(3, 8'hFF), 1'b1, "R2");
    finish_cycle("R5");

    // R3: space mismatch in both directions
    access(win_addr(0, 8'h00), 1'b0, "R3");
    tick("R3");
    cfg_in_io = 1'b0;
    access(win_addr(1, 8'h00), 1'b1, "R3");
    tick("R3");

    // R4: base mismatch in the lowest and highest base bits
    access(win_addr(1, 8'h00) ^ 20'h00400, 1'b0, "R4");
    tick("R4");
    access(win_addr(2, 8'h00) ^ 20'h80000, 1'b0, "R4");
    tick("R4");

    // R9: back-to-back strobes, and a strobe together with cycle end
    access(win_addr(0, 8'h01), 1'b0, "R9");
    access(win_addr(3, 8'h02), 1'b0, "R9");
    cycle_end = 1'b1;
    access(win_addr(1, 8'h03), 1'b0, "R9");
    cycle_end = 1'b0;
    tick("R9");
    access(win_addr(3, 8'h04) ^ 20'h01000, 1'b0, "R9");
    tick("R9");

    // R6: hold ends an active select, strobes ignored while held
    access(win_addr(2, 8'h05), 1'b0, "R6");
    bus_hold = 1'b1;
    tick("R6");
    access(win_addr(1, 8'h06), 1'b0, "R6");
    tick("R6");
    bus_hold = 1'b0;
    tick("R6"); tick("R6");
    access(win_addr(1, 8'h07), 1'b0, "R6");
    finish_cycle("R6");

    // R7: flow control blocks window 2 only
    flow_ctl_en = 1'b1;
    tick("R7");
    access(win_addr(2, 8'h08), 1'b0, "R7");
    tick("R7");
    access(win_addr(1, 8'h09), 1'b0, "R7");
    finish_cycle("R7");
    flow_ctl_en = 1'b0;
    access(win_addr(2, 8'h0A), 1'b0, "R7");
    tick("R7");
    flow_ctl_en = 1'b1;
    tick("R7"); tick("R7");
    flow_ctl_en = 1'b0;
    tick("R7");

    // R8: window sweep of 64 addresses with random low bytes
    for (int n = 0; n < 64; n++) begin
      access(win_addr(n % 4, 8'($urandom)), 1'b0, "R8");
      if (n % 3 == 0) finish_cycle("R8");
    end
    finish_cycle("R8");

    // R1: reset in the middle of an active cycle
    access(win_addr(0, 8'h0B), 1'b0, "R1");
    rst_n = 1'b0;
    #1;
    tests++;
    if (pcs_n !== 4'hF) begin
      fails++;
      $display("FAIL R1: pcs_n=%b expected %b", pcs_n, 4'hF);
    end
    tick("R1");
    rst_n = 1'b1;
    tick("R1");
    access(win_addr(3, 8'h0C), 1'b0, "R2");
    finish_cycle("R5");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule